// File: doc/BRIEF.md
# Auxiliary System Control Register File

This block is a small bank of control and status registers for a workstation I/O controller. A single-cycle register bus reaches seven regions, chosen by a region select. Five are plain storage: configuration, diagnostic, modem control, a 16-bit LED word and a 32-bit system control word. Two are auxiliary registers whose writes have side effects. Each region accepts only one access width, and any other width is rejected with a one-cycle error flag.

Writes to these registers produce side effects as requests for outside logic. A bit in auxiliary register 1 fires a one-cycle floppy terminal-count pulse. Auxiliary register 2 holds a power-off bit, which raises a power-off request pulse, and a sticky power-fail status that software clears by writing a one to it. A bit in the system control word asks for a system reset and latches a reset-status value. A level interrupt reports power-fail status when the configuration register enables it. The power-fail status is sampled on changes of the power-fail input.

There are two resets. `rst_ni` is a hard power-up reset that zeroes everything. `dev_rst_i` is a synchronous device reset that clears configuration, modem control and both auxiliary registers. It leaves diagnostic, LED and system control untouched.

Top module: `aux_ctrl_regs`

## Requirements
- R1: `irq_o` is a registered level equal to power-fail status (auxiliary register 2 bit 5) AND power-interrupt enable (configuration bit 3), valid from the edge that changes either one.
- R2: When `pwr_fail_i` changes level, the power-fail status is loaded with the new input level ANDed with the enable in force after that edge. While the input holds steady, enable changes do not alter the status.
- R3: A legal write to auxiliary register 2 (select 6) takes only data bits 0 and 1 and keeps the current power-fail status. Data bit 1 clears the status and is never stored. A read returns bit 0 and bit 5 only.
- R4: Writing auxiliary register 2 with data bit 0 set stores it and gives a one-cycle `pwr_off_o` pulse on the edge of the write.
- R5: A legal write to auxiliary register 1 (select 5) with data bit 1 set gives a one-cycle `tc_o` pulse. Bit 1 is stored as zero and the other bits are stored as written.
- R6: A legal write to system control (select 4, word size, offset 0) with data bit 0 set loads it with 0x02 and gives a one-cycle `rst_req_o` pulse. A write without bit 0, or at another offset, changes nothing.
- R7: Legal sizes (`size_i` 0 byte, 1 halfword, 2 word, 3 never legal): byte for selects 0, 1, 2, 5, 6; halfword for the LED select 3; word for select 4. A wrong size on a mapped select is ignored on write, reads zero and pulses `err_o` for one cycle. A nonzero offset is ignored on write and reads zero without error.
- R8: `dev_rst_i` clears configuration, modem control and both auxiliary registers, and blocks bus writes in that cycle. Diagnostic, LED and system control keep their values.
- R9: After `rst_ni`, every register and every output is zero.
- R10: Configuration (select 0), diagnostic (1), modem control (2) and LED (3) store legal writes and read them back one cycle later on `rdata_o`, zero-extended. Select 7 is unmapped: it reads zero without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| dev_rst_i | input | 1 | Synchronous device reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| sel_i | input | 3 | Region select |
| size_i | input | 2 | Access size code |
| offs_i | input | OFFS_W | Byte offset within region |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, zero when no legal read |
| err_o | output | 1 | One-cycle illegal-size flag |
| pwr_fail_i | input | 1 | Power-fail input level |
| irq_o | output | 1 | Power-fail interrupt level |
| tc_o | output | 1 | Floppy terminal-count pulse |
| pwr_off_o | output | 1 | Power-off request pulse |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The bench sweeps every select, size code and offset with writes and reads, and keeps an arithmetic model of each register. A decoder that accepted a wrong width or a nonzero offset would corrupt a register or raise a false error, and the read-back would show it. Directed sequences go after the power-fail status. They change the enable while the input is steady, which a design that re-sampled the input would wrongly set. They write the clear bit, which a design could store instead of acting on it. They also write the power-off bit with status set, which a design could use to drop the status. A device reset with every register loaded catches a design that clears the diagnostic, LED or system control word, or one that leaves the interrupt standing.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;

  typedef enum logic [2:0] {
    RG_CFG  = 3'd0,
    RG_DIAG = 3'd1,
    RG_MDM  = 3'd2,
    RG_LED  = 3'd3,
    RG_SYS  = 3'd4,
    RG_AUX1 = 3'd5,
    RG_AUX2 = 3'd6,
    RG_NONE = 3'd7
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  localparam int NREG          = 7;
  localparam int CFG_PF_EN_BIT = 3;
  localparam int AUX1_TC_BIT   = 1;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_PF_BIT   = 5;
  localparam int SYS_RST_BIT   = 0;
  localparam int SYS_STAT_BIT  = 1;

  function automatic size_e region_size(region_e r);
    case (r)
      RG_LED:  return SZ_HALF;
      RG_SYS:  return SZ_WORD;
      RG_NONE: return SZ_BAD;
      default: return SZ_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/aux_access_check.sv
module aux_access_check
  import aux_ctrl_pkg::*;
#(
  parameter int OFFS_W = 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              blk_i,
  input  logic [2:0]        sel_i,
  input  logic [1:0]        size_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic [NREG-1:0]   wr_o,
  output logic              rd_o,
  output logic              err_o
);
  region_e rgn;
  logic    mapped, size_ok, offs_ok, legal;

  always_comb begin
    rgn     = region_e'(sel_i);
    mapped  = (rgn != RG_NONE);
    size_ok = (size_e'(size_i) == region_size(rgn));
    offs_ok = (offs_i == '0);
    legal   = req_i & mapped & size_ok & offs_ok;
    rd_o    = legal & ~we_i;
    err_o   = req_i & mapped & ~size_ok;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_wr
    assign wr_o[g] = legal & we_i & ~blk_i & (sel_i == 3'(g));
  end

endmodule

// File: rtl/aux_field_reg.sv
module aux_field_reg #(
  parameter int W    = 8,
  parameter bit KEEP = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dev_rst_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic clr;

  if (KEEP) begin : g_keep
    logic unused_dev;
    assign unused_dev = dev_rst_i;
    assign clr        = 1'b0;
  end else begin : g_clr
    assign clr = dev_rst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (clr)  q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

endmodule

// File: rtl/aux_pwr_ctrl.sv
module aux_pwr_ctrl
  import aux_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dev_rst_i,
  input  logic       pwr_fail_i,
  input  logic       en_nxt_i,
  input  logic       wr_i,
  input  logic [1:0] wd_i,
  output logic [7:0] aux2_o,
  output logic       pwr_off_o,
  output logic       irq_o
);
  logic pf_q, stat_q, off_q;
  logic stat_d, off_d;

  always_comb begin
    stat_d = stat_q;
    off_d  = off_q;
    if (wr_i) begin
      off_d = wd_i[AUX2_OFF_BIT];
      if (wd_i[AUX2_CLR_BIT]) stat_d = 1'b0;
    end
    // input edge is resolved after the bus write
    if (pwr_fail_i != pf_q) stat_d = pwr_fail_i & en_nxt_i;
    if (dev_rst_i) begin
      stat_d = 1'b0;
      off_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q      <= 1'b0;
      stat_q    <= 1'b0;
      off_q     <= 1'b0;
      pwr_off_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      pf_q      <= pwr_fail_i;
      stat_q    <= stat_d;
      off_q     <= off_d;
      pwr_off_o <= wr_i & wd_i[AUX2_OFF_BIT];
      irq_o     <= stat_d & en_nxt_i;
    end
  end

  always_comb begin
    aux2_o               = '0;
    aux2_o[AUX2_OFF_BIT] = off_q;
    aux2_o[AUX2_PF_BIT]  = stat_q;
  end

endmodule

// File: rtl/aux_ctrl_regs.sv
module aux_ctrl_regs
  import aux_ctrl_pkg::*;
#(
  parameter int OFFS_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [1:0]        size_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              tc_o,
  output logic              pwr_off_o,
  output logic              rst_req_o
);
  localparam int BW = 8;
  localparam int HW = 16;

  logic [NREG-1:0] wr;
  logic            rd, err;
  logic [BW-1:0]   cfg_q, diag_q, mdm_q, aux1_q, aux2_q, sys_q, cfg_nxt;
  logic [HW-1:0]   led_q;
  logic [DATA_W-1:0] rd_val;
  logic            sys_set;
  logic            unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:HW];

  aux_access_check #(.OFFS_W(OFFS_W)) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .blk_i (dev_rst_i),
    .sel_i (sel_i),
    .size_i(size_i),
    .offs_i(offs_i),
    .wr_o  (wr),
    .rd_o  (rd),
    .err_o (err)
  );

  aux_field_reg #(.W(BW), .KEEP(1'b0)) u_cfg (
    .clk_i, .rst_ni, .dev_rst_i,
    .en_i(wr[RG_CFG]), .d_i(wdata_i[BW-1:0]), .q_o(cfg_q)
  );

  aux_field_reg #(.W(BW), .KEEP(1'b1)) u_diag (
    .clk_i, .rst_ni, .dev_rst_i,
    .en_i(wr[RG_DIAG]), .d_i(wdata_i[BW-1:0]), .q_o(diag_q)
  );

  aux_field_reg #(.W(BW), .KEEP(1'b0)) u_mdm (
    .clk_i, .rst_ni, .dev_rst_i,
    .en_i(wr[RG_MDM]), .d_i(wdata_i[BW-1:0]), .q_o(mdm_q)
  );

  aux_field_reg #(.W(HW), .KEEP(1'b1)) u_led (
    .clk_i, .rst_ni, .dev_rst_i,
    .en_i(wr[RG_LED]), .d_i(wdata_i[HW-1:0]), .q_o(led_q)
  );

  aux_field_reg #(.W(BW), .KEEP(1'b0)) u_aux1 (
    .clk_i, .rst_ni, .dev_rst_i,
    .en_i(wr[RG_AUX1]),
    .d_i (wdata_i[BW-1:0] & ~(BW'(1) << AUX1_TC_BIT)),
    .q_o (aux1_q)
  );

  assign sys_set = wr[RG_SYS] & wdata_i[SYS_RST_BIT];

  aux_field_reg #(.W(BW), .KEEP(1'b1)) u_sys (
    .clk_i, .rst_ni, .dev_rst_i,
    .en_i(sys_set), .d_i(BW'(1) << SYS_STAT_BIT), .q_o(sys_q)
  );

  always_comb begin
    if (dev_rst_i)         cfg_nxt = '0;
    else if (wr[RG_CFG])   cfg_nxt = wdata_i[BW-1:0];
    else                   cfg_nxt = cfg_q;
  end

  aux_pwr_ctrl u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_rst_i (dev_rst_i),
    .pwr_fail_i(pwr_fail_i),
    .en_nxt_i  (cfg_nxt[CFG_PF_EN_BIT]),
    .wr_i      (wr[RG_AUX2]),
    .wd_i      (wdata_i[1:0]),
    .aux2_o    (aux2_q),
    .pwr_off_o (pwr_off_o),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_val = '0;
    case (region_e'(sel_i))
      RG_CFG:  rd_val = DATA_W'(cfg_q);
      RG_DIAG: rd_val = DATA_W'(diag_q);
      RG_MDM:  rd_val = DATA_W'(mdm_q);
      RG_LED:  rd_val = DATA_W'(led_q);
      RG_SYS:  rd_val = DATA_W'(sys_q);
      RG_AUX1: rd_val = DATA_W'(aux1_q);
      RG_AUX2: rd_val = DATA_W'(aux2_q);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      err_o     <= 1'b0;
      tc_o      <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rdata_o   <= rd ? rd_val : '0;
      err_o     <= err;
      tc_o      <= wr[RG_AUX1] & wdata_i[AUX1_TC_BIT];
      rst_req_o <= sys_set;
    end
  end

endmodule

// File: rtl/aux_ctrl_regs_chk.sv
module aux_ctrl_regs_chk #(
  parameter int OFFS_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dev_rst_i,
  input logic              req_i,
  input logic              we_i,
  input logic [2:0]        sel_i,
  input logic [1:0]        size_i,
  input logic [OFFS_W-1:0] offs_i,
  input logic              wd_tc,
  input logic              irq_o,
  input logic              tc_o,
  input logic              pwr_off_o,
  input logic              rst_req_o,
  input logic              err_o,
  input logic [7:0]        cfg_q,
  input logic [7:0]        mdm_q,
  input logic [7:0]        aux1_q,
  input logic [7:0]        aux2_q,
  input logic [7:0]        sys_q
);

  a_r1_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (aux2_q[5] && cfg_q[3]));

  a_r3_aux2_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux2_q & 8'hDE) == 8'h00);

  a_r4_off_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o |-> aux2_q[0]);

  a_r5_tc_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(req_i && we_i && sel_i == 3'd5 && size_i == 2'd0 &&
                   offs_i == '0 && wd_tc && !dev_rst_i));

  a_r5_tc_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux1_q[1]);

  a_r6_rst_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> sys_q == 8'h02);

  a_r6_sys_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_q == 8'h00 || sys_q == 8'h02);

  a_r7_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));

  a_r8_dev_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dev_rst_i) |-> (cfg_q == 8'h00 && mdm_q == 8'h00 &&
                          aux1_q == 8'h00 && aux2_q == 8'h00 && !irq_o));

endmodule

bind aux_ctrl_regs aux_ctrl_regs_chk #(.OFFS_W(OFFS_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dev_rst_i(dev_rst_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .sel_i    (sel_i),
  .size_i   (size_i),
  .offs_i   (offs_i),
  .wd_tc    (wdata_i[1]),
  .irq_o    (irq_o),
  .tc_o     (tc_o),
  .pwr_off_o(pwr_off_o),
  .rst_req_o(rst_req_o),
  .err_o    (err_o),
  .cfg_q    (cfg_q),
  .mdm_q    (mdm_q),
  .aux1_q   (aux1_q),
  .aux2_q   (aux2_q),
  .sys_q    (sys_q)
);

// File: tb/aux_ctrl_regs_tb.sv
module aux_ctrl_regs_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dev_rst_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  sel_i = '0;
  logic [1:0]  size_i = '0;
  logic [1:0]  offs_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o, irq_o, tc_o, pwr_off_o, rst_req_o;
  logic        pwr_fail_i = 1'b0;

  int errs = 0;
  int checks = 0;

  logic [7:0]  m_cfg = 0, m_diag = 0, m_mdm = 0, m_aux1 = 0, m_aux2 = 0, m_sys = 0;
  logic [15:0] m_led = 0;
  logic [31:0] g_rdata;
  logic        g_err, g_tc, g_off, g_rst, g_irq;
  logic [3:0]  g_post;

  always #(CLK_NS/2) clk = ~clk;

  aux_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni, .dev_rst_i, .req_i, .we_i, .sel_i, .size_i,
    .offs_i, .wdata_i, .rdata_o, .err_o, .pwr_fail_i, .irq_o, .tc_o,
    .pwr_off_o, .rst_req_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_size(input logic [2:0] s);
    return (s == 3'd3) ? 2'd1 : (s == 3'd4) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic legal(input logic [2:0] s, input logic [1:0] z, input logic [1:0] o);
    return s != 3'd7 && z == exp_size(s) && o == 2'd0;
  endfunction

  function automatic logic [31:0] m_val(input logic [2:0] s);
    case (s)
      3'd0: return {24'd0, m_cfg};
      3'd1: return {24'd0, m_diag};
      3'd2: return {24'd0, m_mdm};
      3'd3: return {16'd0, m_led};
      3'd4: return {24'd0, m_sys};
      3'd5: return {24'd0, m_aux1};
      3'd6: return {24'd0, m_aux2};
      default: return 32'd0;
    endcase
  endfunction

  task automatic acc(input logic w, input logic [2:0] s, input logic [1:0] z,
                     input logic [1:0] o, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = w; sel_i = s; size_i = z; offs_i = o; wdata_i = d;
    @(posedge clk); #1;
    g_rdata = rdata_o; g_err = err_o; g_tc = tc_o; g_off = pwr_off_o;
    g_rst = rst_req_o; g_irq = irq_o;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
    @(posedge clk); #1;
    g_post = {tc_o, pwr_off_o, rst_req_o, err_o};
  endtask

  task automatic wr_chk(input string tag, input logic [2:0] s, input logic [1:0] z,
                        input logic [1:0] o, input logic [31:0] d);
    logic e_tc, e_off, e_rst, e_err, pf;
    e_tc = 0; e_off = 0; e_rst = 0;
    e_err = (s != 3'd7) && (z != exp_size(s));
    if (legal(s, z, o)) begin
      case (s)
        3'd0: m_cfg = d[7:0];
        3'd1: m_diag = d[7:0];
        3'd2: m_mdm = d[7:0];
        3'd3: m_led = d[15:0];
        3'd4: if (d[0]) begin m_sys = 8'h02; e_rst = 1; end
        3'd5: begin m_aux1 = d[7:0] & 8'hFD; e_tc = d[1]; end
        3'd6: begin
          pf = m_aux2[5] & ~d[1];
          m_aux2 = {2'b00, pf, 4'b0000, d[0]};
          e_off = d[0];
        end
        default: ;
      endcase
    end
    acc(1'b1, s, z, o, d);
    chk({tag, " err"}, {31'd0, g_err}, {31'd0, e_err});
    chk({tag, " tc R5"}, {31'd0, g_tc}, {31'd0, e_tc});
    chk({tag, " off R4"}, {31'd0, g_off}, {31'd0, e_off});
    chk({tag, " rstreq R6"}, {31'd0, g_rst}, {31'd0, e_rst});
    chk({tag, " irq R1"}, {31'd0, g_irq}, {31'd0, m_aux2[5] & m_cfg[3]});
    chk({tag, " pulses one cycle"}, {28'd0, g_post}, 32'd0);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] s, input logic [1:0] z,
                        input logic [1:0] o);
    acc(1'b0, s, z, o, 32'd0);
    chk({tag, " rdata"}, g_rdata, legal(s, z, o) ? m_val(s) : 32'd0);
    chk({tag, " err R7"}, {31'd0, g_err},
        {31'd0, (s != 3'd7) && (z != exp_size(s))});
  endtask

  task automatic rd_reg(input string tag, input logic [2:0] s);
    rd_chk(tag, s, exp_size(s), 2'd0);
  endtask

  task automatic set_pf(input string tag, input logic v);
    logic chg;
    chg = (v != pwr_fail_i);
    @(negedge clk);
    pwr_fail_i = v;
    if (chg) m_aux2[5] = v & m_cfg[3];
    @(posedge clk); #1;
    chk({tag, " irq R2"}, {31'd0, irq_o}, {31'd0, m_aux2[5] & m_cfg[3]});
    rd_reg({tag, " status R2"}, 3'd6);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errs++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R9: hard reset state
    chk("R9 outputs", {27'd0, irq_o, tc_o, pwr_off_o, rst_req_o, err_o}, 32'd0);
    for (int s = 0; s < 8; s++) rd_reg("R9 reg", 3'(s));

    // R10: plain storage, unmapped select
    wr_chk("R10 cfg", 3'd0, 2'd0, 2'd0, 32'h0000_005A);
    wr_chk("R10 diag", 3'd1, 2'd0, 2'd0, 32'h0000_00C3);
    wr_chk("R10 mdm", 3'd2, 2'd0, 2'd0, 32'h0000_003C);
    wr_chk("R10 led", 3'd3, 2'd1, 2'd0, 32'h1234_BEEF);
    for (int s = 0; s < 4; s++) rd_reg("R10 readback", 3'(s));
    rd_chk("R10 unmapped", 3'd7, 2'd0, 2'd0);

    // R5: terminal count bit
    wr_chk("R5 tc set", 3'd5, 2'd0, 2'd0, 32'h0000_00FF);
    rd_reg("R5 tc stored zero", 3'd5);
    wr_chk("R5 tc clear", 3'd5, 2'd0, 2'd0, 32'h0000_0044);
    rd_reg("R5 other bits", 3'd5);

    // R6: system control
    wr_chk("R6 no bit0", 3'd4, 2'd2, 2'd0, 32'hFFFF_FFFE);
    rd_reg("R6 unchanged", 3'd4);
    wr_chk("R6 offset1", 3'd4, 2'd2, 2'd1, 32'h0000_0001);
    rd_reg("R6 offset ignored", 3'd4);
    wr_chk("R6 reset req", 3'd4, 2'd2, 2'd0, 32'h0000_0001);
    rd_reg("R6 status", 3'd4);

    // R1..R4: power fail handling
    wr_chk("R1 enable", 3'd0, 2'd0, 2'd0, 32'h0000_0008);
    set_pf("R2 rise enabled", 1'b1);
    wr_chk("R3 carry R4 off", 3'd6, 2'd0, 2'd0, 32'h0000_0001);
    rd_reg("R3 carry", 3'd6);
    wr_chk("R1 disable", 3'd0, 2'd0, 2'd0, 32'h0000_0000);
    rd_reg("R1 status kept", 3'd6);
    wr_chk("R1 re-enable", 3'd0, 2'd0, 2'd0, 32'h0000_0008);
    wr_chk("R3 clear", 3'd6, 2'd0, 2'd0, 32'h0000_00FE);
    rd_reg("R3 cleared", 3'd6);
    set_pf("R2 fall after clear", 1'b0);
    wr_chk("R2 disable", 3'd0, 2'd0, 2'd0, 32'h0000_0000);
    set_pf("R2 rise disabled", 1'b1);
    wr_chk("R2 enable steady", 3'd0, 2'd0, 2'd0, 32'h0000_0008);
    rd_reg("R2 no resample", 3'd6);
    set_pf("R2 fall", 1'b0);
    set_pf("R2 rise", 1'b1);
    set_pf("R2 fall clears", 1'b0);

    // R8: device reset
    set_pf("R8 prep", 1'b1);
    wr_chk("R8 aux1", 3'd5, 2'd0, 2'd0, 32'h0000_0081);
    wr_chk("R8 mdm", 3'd2, 2'd0, 2'd0, 32'h0000_0077);
    wr_chk("R8 aux2", 3'd6, 2'd0, 2'd0, 32'h0000_0001);
    @(negedge clk);
    dev_rst_i = 1'b1;
    req_i = 1'b1; we_i = 1'b1; sel_i = 3'd1; size_i = 2'd0; offs_i = 2'd0;
    wdata_i = 32'h0000_0011;
    @(posedge clk); #1;
    m_cfg = 0; m_aux1 = 0; m_aux2 = 0; m_mdm = 0;
    chk("R8 irq", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    dev_rst_i = 1'b0; req_i = 1'b0; we_i = 1'b0;
    for (int s = 0; s < 7; s++) rd_reg("R8 after", 3'(s));
    set_pf("R8 done", 1'b0);

    // R7: sweep of select, size and offset
    for (int s = 0; s < 8; s++)
      for (int z = 0; z < 4; z++)
        for (int o = 0; o < 4; o++) begin
          logic [7:0] b;
          string t;
          b = 8'(s * 53 + z * 17 + o * 7 + 1);
          t = legal(3'(s), 2'(z), 2'(o)) ? "R10 sweep" : "R7 sweep";
          wr_chk(t, 3'(s), 2'(z), 2'(o), {b, ~b, b ^ 8'h5A, b});
          rd_chk(t, 3'(s), 2'(z), 2'(o));
          rd_reg("R7 sweep state", 3'(s));
        end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule